// File: doc/BRIEF.md
# Fractional-Increment Real-Time Counter

This block keeps time of day as a 64-bit fixed-point value: a 32-bit whole-seconds field and a 32-bit sub-second fraction. Each low-frequency tick, delivered as a one-cycle strobe synchronous to the register clock, adds a programmable step to the fraction. A carry out of the fraction adds one to the seconds. With the reset step of 0x0002_0000, one second builds up every 32768 ticks, which matches a 32.768 kHz tick source. Software can tune the step to trim a drifting tick source.

Software reaches the block through a small synchronous register port. A control register has a run bit and a self-clearing clear bit. Reading the seconds register also copies the live fraction into a shadow register. A later read of the fraction register returns that shadow, so the two reads form one consistent timestamp. A compact view packs the low 16 seconds bits with the upper 16 fraction bits into one 32-bit word.

Top module: `rtc_frac_counter`

## Requirements
- R1: Out of reset the seconds and fraction are zero, the run bit is 0, the step register holds 0x0002_0000 and read data is zero.
- R2: On each tick while the run bit (control address 0, bit 0) is set, the step (address 3, read/write) is added modulo 2^32 to the fraction.
- R3: When the addition in R2 carries out of bit 31, seconds increase by one on the same tick.
- R4: With the run bit clear, or with no tick, seconds and fraction hold their value.
- R5: Writing 1 to control bit 1 zeroes seconds and fraction one cycle after the write. The bit reads back 1 only during that cycle and then clears by itself. The run bit takes the written bit 0.
- R6: A read of address 1 returns the seconds and copies the current fraction into a shadow. A read of address 2 returns the shadow, and ticks after the seconds read do not change it.
- R7: A read of address 4 returns seconds bits 15:0 in bits 31:16 and fraction bits 31:16 in bits 15:0.
- R8: Read data appears on rdata in the cycle after rd_en is sampled. Unmapped addresses (5 to 7) read zero.
- R9: When a seconds read and a tick occur in the same cycle, the returned seconds and the captured shadow are both the values before that tick.
- R10: Writes to the read-only addresses 1, 2 and 4 change nothing.
- R11: Control bit 0 reads back the run state, so software can tell whether counting is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle time-base strobe |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
The bench drives the fraction past its top with several steps. This includes a step of 0xFFFF_FFFF, and a design that dropped or delayed the carry would show the wrong seconds. It lands a tick on the same cycle as a seconds read. A design that captured the shadow after the add would return a torn pair, with old seconds and a new fraction. It also reads the clear bit in the one cycle it should be set and again just after. A clear that stuck, or took effect a cycle late, would appear in that readback or as leftover time. A default-step run of 32768 ticks checks that the reset step yields exactly one second.

// File: rtl/rtc_frac_pkg.sv
// Package: register addresses and control bit positions shared by the
// counter's register logic and read port.
package rtc_frac_pkg;
    localparam int ADDR_W       = 3;
    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_CLR_BIT = 1;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 3'd0,
        REG_SECS = 3'd1,
        REG_FRAC = 3'd2,
        REG_STEP = 3'd3,
        REG_VIEW = 3'd4
    } reg_sel_e;
endpackage

// File: rtl/rtc_time_accum.sv
// Module: rtc_time_accum
// Holds the seconds/fraction pair. On add_en, the step is added to the
// fraction and the carry out goes into the seconds in the same cycle. On clr,
// both fields are zeroed. Assumes the controller never raises both at once;
// if it did, clr would win.
module rtc_time_accum #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         add_en,
    input  logic         clr,
    input  logic [W-1:0] step,
    output logic [W-1:0] sec,
    output logic [W-1:0] frac
);
    logic [W:0] frac_sum;

    // Fraction plus step, with the carry in the top bit.
    always_comb frac_sum = {1'b0, frac} + {1'b0, step};

    // Update the time pair: clear, accumulate or hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sec  <= '0;
            frac <= '0;
        end else if (add_en) begin
            frac <= frac_sum[W-1:0];
            sec  <= sec + {{(W-1){1'b0}}, frac_sum[W]};
        end
    end

    AST_FRAC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && !clr) |=> frac == $past(frac) + $past(step)); // R2
    AST_SEC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && !clr) |=> sec == ((frac < $past(frac)) ? $past(sec) + 1'b1 : $past(sec))); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!add_en && !clr) |=> ($stable(sec) && $stable(frac))); // R4
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sec == '0 && frac == '0)); // R5
endmodule

// File: rtl/rtc_ctrl_regs.sv
// Module: rtc_ctrl_regs
// Writable state: the run bit, the one-cycle clear pulse, the step and the
// fraction shadow. It also gates tick into the accumulate enable. Assumes tick
// is a one-cycle strobe in the clk domain.
module rtc_ctrl_regs
    import rtc_frac_pkg::*;
#(
    parameter int         W          = 32,
    parameter logic [W-1:0] STEP_RESET = 32'h0002_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      frac,
    output logic              run_q,
    output logic              clr_q,
    output logic [W-1:0]      step_q,
    output logic [W-1:0]      shadow_q,
    output logic              add_en
);
    logic ctrl_wr;
    logic secs_rd;

    // Address decode for the two strobes that touch state here.
    always_comb begin
        ctrl_wr = wr_en && (addr == REG_CTRL);
        secs_rd = rd_en && (addr == REG_SECS);
    end

    // Run bit and self-clearing clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            clr_q <= 1'b0;
        end else begin
            if (ctrl_wr) run_q <= wdata[CTRL_RUN_BIT];
            clr_q <= ctrl_wr && wdata[CTRL_CLR_BIT];
        end
    end

    // Programmable sub-second step.
    always_ff @(posedge clk) begin
        if (!rst_n)                            step_q <= STEP_RESET;
        else if (wr_en && addr == REG_STEP)   step_q <= wdata;
    end

    // Snapshot the fraction whenever seconds are read.
    always_ff @(posedge clk) begin
        if (!rst_n)       shadow_q <= '0;
        else if (secs_rd) shadow_q <= frac;
    end

    // A tick counts only while running and not being cleared.
    always_comb add_en = tick && run_q && !clr_q;

    AST_CLR_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_q && !(ctrl_wr && wdata[CTRL_CLR_BIT])) |=> !clr_q); // R5
    AST_SHADOW_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        secs_rd |=> shadow_q == $past(frac)); // R6
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !secs_rd |=> $stable(shadow_q)); // R6
endmodule

// File: rtl/rtc_read_port.sv
// Module: rtc_read_port
// Registered read mux. Data for a read sampled on rd_en is presented the
// next cycle and held until the next read. Unmapped addresses return zero.
module rtc_read_port
    import rtc_frac_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              run_q,
    input  logic              clr_q,
    input  logic [W-1:0]      sec,
    input  logic [W-1:0]      frac,
    input  logic [W-1:0]      step_q,
    input  logic [W-1:0]      shadow_q,
    output logic [W-1:0]      rdata
);
    localparam int HALF = W / 2;

    logic [W-1:0] view;
    logic [W-1:0] rd_mux;

    // Compact view: low seconds over high fraction.
    always_comb view = {sec[HALF-1:0], frac[W-1:W-HALF]};

    // Select the word for the addressed register.
    always_comb begin
        rd_mux = '0;
        case (addr)
            REG_CTRL: begin
                rd_mux[CTRL_RUN_BIT] = run_q;
                rd_mux[CTRL_CLR_BIT] = clr_q;
            end
            REG_SECS: rd_mux = sec;
            REG_FRAC: rd_mux = shadow_q;
            REG_STEP: rd_mux = step_q;
            REG_VIEW: rd_mux = view;
            default:  rd_mux = '0;
        endcase
    end

    // Register the read data on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    AST_VIEW_PACK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == REG_VIEW) |=> rdata == {$past(sec[HALF-1:0]), $past(frac[W-1:W-HALF])}); // R7
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr > REG_VIEW) |=> rdata == '0); // R8
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R8
endmodule

// File: rtl/rtc_frac_counter.sv
// Module: rtc_frac_counter (top)
// A 32.32 real-time counter that advances by a programmable step on each
// tick, behind a synchronous register port. Assumes tick, wr_en and rd_en are
// single-cycle strobes in the clk domain.
module rtc_frac_counter #(
    parameter int          DATA_W     = 32,
    parameter logic [31:0] STEP_RESET = 32'h0002_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic              run_q;
    logic              clr_q;
    logic              add_en;
    logic [DATA_W-1:0] step_q;
    logic [DATA_W-1:0] shadow_q;
    logic [DATA_W-1:0] sec;
    logic [DATA_W-1:0] frac;

    rtc_ctrl_regs #(.W(DATA_W), .STEP_RESET(STEP_RESET[DATA_W-1:0])) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .frac(frac), .run_q(run_q), .clr_q(clr_q),
        .step_q(step_q), .shadow_q(shadow_q), .add_en(add_en)
    );

    rtc_time_accum #(.W(DATA_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .add_en(add_en), .clr(clr_q),
        .step(step_q), .sec(sec), .frac(frac)
    );

    rtc_read_port #(.W(DATA_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .run_q(run_q),
        .clr_q(clr_q), .sec(sec), .frac(frac), .step_q(step_q),
        .shadow_q(shadow_q), .rdata(rdata)
    );
endmodule

// File: tb/rtc_frac_counter_tb.sv
module rtc_frac_counter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rtc_frac_counter u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    // {step, ticks, expected seconds, expected fraction}, each from zero
    localparam logic [127:0] VEC [5] = '{
        {32'h0002_0000, 32'd5, 32'd0, 32'h000A_0000},
        {32'h8000_0000, 32'd3, 32'd1, 32'h8000_0000},
        {32'hFFFF_FFFF, 32'd2, 32'd1, 32'hFFFF_FFFE},
        {32'h0000_0001, 32'd4, 32'd0, 32'h0000_0004},
        {32'h4000_0000, 32'd8, 32'd2, 32'h0000_0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // All tasks start and end on a falling edge.
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
        end
        tick = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 rdata", rdata, 32'h0);
        rd(3'd0, d); check("R1 ctrl", d, 32'h0);
        rd(3'd1, d); check("R1 secs", d, 32'h0);
        rd(3'd2, d); check("R1 frac", d, 32'h0);
        rd(3'd3, d); check("R1 step", d, 32'h0002_0000);
        // R4 ticks ignored while stopped
        pulse(10);
        rd(3'd1, d); check("R4 secs stopped", d, 32'h0);
        rd(3'd2, d); check("R4 frac stopped", d, 32'h0);
        // R11 run bit readback
        wr(3'd0, 32'h1);
        rd(3'd0, d); check("R11 ctrl run", d, 32'h1);
        // R3 default step: 32768 ticks make one second
        pulse(32768);
        rd(3'd1, d); check("R3 secs one second", d, 32'd1);
        rd(3'd2, d); check("R3 frac wrapped", d, 32'h0);
        pulse(3);
        rd(3'd4, d); check("R7 view", d, 32'h0001_0006);
        // R4 running but no tick
        repeat (5) @(negedge clk);
        rd(3'd4, d); check("R4 hold no tick", d, 32'h0001_0006);
        // R10 writes to read-only addresses ignored
        wr(3'd1, 32'h1234_5678);
        wr(3'd2, 32'h1234_5678);
        wr(3'd4, 32'h1234_5678);
        rd(3'd1, d); check("R10 secs unchanged", d, 32'd1);
        rd(3'd2, d); check("R10 frac unchanged", d, 32'h0006_0000);
        // R8 unmapped addresses
        for (int a = 5; a < 8; a++) begin
            rd(3'(a), d); check("R8 unmapped", d, 32'h0);
        end
        // R5 clear pulse visible for one cycle, then self-clears
        wr(3'd0, 32'h3);
        rd(3'd0, d); check("R5 clear bit set", d, 32'h3);
        rd(3'd0, d); check("R5 clear bit self-cleared", d, 32'h1);
        rd(3'd1, d); check("R5 secs cleared", d, 32'h0);
        rd(3'd2, d); check("R5 frac cleared", d, 32'h0);
        // R2/R3 vector table
        foreach (VEC[i]) begin
            wr(3'd0, 32'h2);
            wr(3'd3, VEC[i][127:96]);
            rd(3'd3, d); check("R2 step readback", d, VEC[i][127:96]);
            wr(3'd0, 32'h1);
            pulse(int'(VEC[i][95:64]));
            wr(3'd0, 32'h0);
            rd(3'd1, d); check("R3 vector secs", d, VEC[i][63:32]);
            rd(3'd2, d); check("R2 vector frac", d, VEC[i][31:0]);
        end
        // R9 tick coinciding with seconds read; R6 shadow stable afterwards
        wr(3'd0, 32'h2);
        wr(3'd3, 32'h8000_0000);
        wr(3'd0, 32'h1);
        pulse(1);
        rd_en = 1'b1; addr = 3'd1; tick = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; tick = 1'b0;
        check("R9 secs pre-tick", rdata, 32'd0);
        pulse(2);
        rd(3'd2, d); check("R9 R6 shadow pre-tick", d, 32'h8000_0000);
        rd(3'd1, d); check("R6 secs after ticks", d, 32'd2);
        rd(3'd2, d); check("R6 new shadow", d, 32'h0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end
endmodule